// File: doc/BRIEF.md
# Cluster Event and Barrier Synchronizer

This block lets the cores of a multi-core cluster sleep until something worth waking for happens. Each core owns a private register port into the unit. A core parks itself by issuing a read to one of two wait registers: one waits for generic events, the other for a barrier. If the condition does not already hold, the unit keeps that read outstanding and drops the core's clock enable. Once the condition holds, the unit raises the enable again and returns the read data in the same cycle, so the core continues from the load that parked it.

Events reach a core in two ways. An external line per core and event bit can raise them, and any core can raise them by writing to a trigger register. Events stay pending until a completed event wait consumes them, and only the bits selected by the core's event mask can wake it. The barrier has a shared participation mask. It releases every core parked on it once all participating cores have arrived, and its arrival record clears on release, so the same barrier can be used again straight away.

Top module: `evu_top`

## Requirements
- R1: Register map, per core, at a 3-bit address: 0 is the event mask (read/write, bits [7:0]); 1 reads the pending events and, when written, triggers events; 2 is the shared barrier participation mask (read/write, bits [7:0], reset value 0xFF); 3 is the event wait; 4 is the barrier wait. An accepted ordinary read gives rsp_valid with zero-extended rsp_rdata in the cycle after the accepting edge, for one cycle.
- R2: req_ready of a core is low exactly while that core is parked, and a request presented then is not taken. A write held during that time does not change the register it targets.
- R3: An event wait accepted while (pending AND mask) is nonzero completes in the next cycle, returns those bits in rsp_rdata[7:0] and clears only them. clk_en stays high throughout. Pending bits outside the mask are kept.
- R4: An event wait with no masked pending event parks the core: clk_en goes low from the cycle after acceptance. If an event is captured at edge E, then after edge E+1 clk_en is high and rsp_valid carries the masked bits.
- R5: A write to address 1 raises the event bits in wdata[7:0] in each core whose bit is set in wdata[15:8], including the writer itself. These bits are ORed with the external lines captured at the same edge.
- R6: An event captured at the same edge at which an event wait consumes that same bit remains pending.
- R7: A read of address 4 records arrival and parks the core. One edge after every participating core has arrived, all cores parked on the barrier wake together. The last arriver is parked for exactly one cycle. Each returns the participation mask.
- R8: Arrival state clears on release, so an immediate second use of the barrier needs every participant to arrive again.
- R9: With an empty participation mask the barrier never releases. A parked non-participant is released by the next release. A mask written while cores are parked takes effect from the following edge.
- R10: Writes to addresses 3 to 7 are ignored, and reads of addresses 5 to 7 return 0. When several cores write the participation mask at one edge, the lowest-numbered core wins.
- R11: After reset every clk_en and req_ready is 1, no rsp_valid is set, and masks and pending events are 0 apart from the participation mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NC | Per-core request valid, held until accepted |
| req_ready | output | NC | Per-core request ready (low while parked) |
| req_write | input | NC | Per-core write (1) or read (0) |
| req_addr | input | NC*AW | Per-core register address |
| req_wdata | input | NC*DW | Per-core write data |
| rsp_valid | output | NC | Per-core read response; no back-pressure, the core consumes it at once |
| rsp_rdata | output | NC*DW | Per-core read data |
| evt_in | input | NC*NE | External event lines, NE per core, sampled each edge |
| core_clk_en | output | NC | Per-core clock enable for the gating cell |

## Verification
Two pairs of functions are made to coincide. In the first, an external event line is pulsed on the exact edge where a parked core's event wait consumes that same bit. The bench then reads the pending register and expects the bit to survive. In the second, a software trigger and an external line hit the same core at one edge, and the later wait must return the OR of both. A behavioural reference model, run every clock, judges all ports, including the barrier edge where a late non-participant arrival meets a release.

// File: rtl/evu_pkg.sv
package evu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RESP = 2'd1,
    ST_WEVT = 2'd2,
    ST_WBAR = 2'd3
  } port_st_e;

  localparam int unsigned A_EMASK = 0;
  localparam int unsigned A_PEND  = 1;
  localparam int unsigned A_BMASK = 2;
  localparam int unsigned A_WEVT  = 3;
  localparam int unsigned A_WBAR  = 4;
endpackage

// File: rtl/evu_barrier.sv
module evu_barrier #(
  parameter int NC = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NC-1:0]          arrive,
  input  logic [NC-1:0]          bm_we,
  input  logic [NC-1:0][NC-1:0]  bm_wdata,
  output logic                   bar_release,
  output logic [NC-1:0]          bar_mask
);
  logic [NC-1:0] mask_q, mask_d, arr_q;

  assign bar_mask    = mask_q;
  assign bar_release = (mask_q != '0) && ((arr_q & mask_q) == mask_q);

  always_comb begin
    mask_d = mask_q;
    for (int j = NC - 1; j >= 0; j--) begin
      if (bm_we[j]) mask_d = bm_wdata[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      arr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      arr_q  <= (bar_release ? '0 : arr_q) | arrive;
    end
  end

  // R9: an empty participation set never opens the barrier
  a_r9_empty_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !bar_release);
  // R7: a missing participant blocks release
  a_r7_missing_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~arr_q) != '0) |-> !bar_release);
  // R8: after release only new arrivals remain recorded
  a_r8_cleared_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    bar_release |=> ((arr_q & ~$past(arrive)) == '0));
endmodule

// File: rtl/evu_port.sv
module evu_port
  import evu_pkg::*;
#(
  parameter int NC = 8,
  parameter int NE = 8,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NE-1:0]  evt_new,
  input  logic           bar_release,
  input  logic [NC-1:0]  bar_mask,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           clk_en,
  output logic           arrive,
  output logic           trig_valid,
  output logic [NE-1:0]  trig_evt,
  output logic [NC-1:0]  trig_cores,
  output logic           bm_we,
  output logic [NC-1:0]  bm_wdata
);
  port_st_e      st_q, st_d;
  logic [NE-1:0] emask_q, pend_q, hit, clr;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          parked, accept, is_rd, is_wr;

  assign parked    = (st_q == ST_WEVT) || (st_q == ST_WBAR);
  assign req_ready = !parked;
  assign clk_en    = !parked;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rdata_q;

  assign accept = req_valid && req_ready;
  assign is_rd  = accept && !req_write;
  assign is_wr  = accept && req_write;
  assign hit    = pend_q & emask_q;

  assign trig_valid = is_wr && (req_addr == AW'(A_PEND));
  assign trig_evt   = req_wdata[NE-1:0];
  assign trig_cores = req_wdata[NE +: NC];
  assign bm_we      = is_wr && (req_addr == AW'(A_BMASK));
  assign bm_wdata   = req_wdata[NC-1:0];

  always_comb begin
    st_d    = st_q;
    rdata_d = rdata_q;
    clr     = '0;
    arrive  = 1'b0;
    unique case (st_q)
      ST_WEVT: begin
        if (hit != '0) begin
          st_d    = ST_RESP;
          rdata_d = DW'(hit);
          clr     = hit;
        end
      end
      ST_WBAR: begin
        if (bar_release) begin
          st_d    = ST_RESP;
          rdata_d = DW'(bar_mask);
        end
      end
      default: begin
        st_d = ST_IDLE;
        if (is_rd) begin
          st_d = ST_RESP;
          if (req_addr == AW'(A_EMASK))      rdata_d = DW'(emask_q);
          else if (req_addr == AW'(A_PEND))  rdata_d = DW'(pend_q);
          else if (req_addr == AW'(A_BMASK)) rdata_d = DW'(bar_mask);
          else if (req_addr == AW'(A_WEVT)) begin
            if (hit != '0) begin
              rdata_d = DW'(hit);
              clr     = hit;
            end else begin
              st_d = ST_WEVT;
            end
          end else if (req_addr == AW'(A_WBAR)) begin
            st_d   = ST_WBAR;
            arrive = 1'b1;
          end else begin
            rdata_d = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
      emask_q <= '0;
      pend_q  <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      pend_q  <= (pend_q & ~clr) | evt_new;
      if (is_wr && (req_addr == AW'(A_EMASK))) emask_q <= req_wdata[NE-1:0];
    end
  end

  // R2: a parked core never sees a response
  a_r2_parked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !rsp_valid);
  // R4: an event wait with nothing masked pending stays parked
  a_r4_stays_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WEVT) && ((pend_q & emask_q) == '0)) |=> !clk_en);
  // R3: a pending bit only disappears by being returned
  a_r3_clear_only_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q) != '0) |->
      (rsp_valid && (($past(pend_q) & ~pend_q & ~rdata_q[NE-1:0]) == '0)));
endmodule

// File: rtl/evu_top.sv
module evu_top #(
  parameter int NC = 8,
  parameter int NE = 8,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC-1:0]     req_valid,
  output logic [NC-1:0]     req_ready,
  input  logic [NC-1:0]     req_write,
  input  logic [NC*AW-1:0]  req_addr,
  input  logic [NC*DW-1:0]  req_wdata,
  output logic [NC-1:0]     rsp_valid,
  output logic [NC*DW-1:0]  rsp_rdata,
  input  logic [NC*NE-1:0]  evt_in,
  output logic [NC-1:0]     core_clk_en
);
  localparam int TRIG_BITS = NE + NC;

  logic [NC-1:0]         arrive, trig_valid, bm_we;
  logic [NC-1:0][NE-1:0] trig_evt, evt_new;
  logic [NC-1:0][NC-1:0] trig_cores, bm_wdata;
  logic [NC-1:0]         bar_mask;
  logic                  bar_release;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      evt_new[i] = evt_in[i*NE +: NE];
      for (int j = 0; j < NC; j++) begin
        if (trig_valid[j] && trig_cores[j][i]) evt_new[i] = evt_new[i] | trig_evt[j];
      end
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_port
    evu_port #(.NC(NC), .NE(NE), .AW(AW), .DW(DW)) i_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[g]),
      .req_write  (req_write[g]),
      .req_addr   (req_addr[g*AW +: AW]),
      .req_wdata  (req_wdata[g*DW +: DW]),
      .evt_new    (evt_new[g]),
      .bar_release(bar_release),
      .bar_mask   (bar_mask),
      .req_ready  (req_ready[g]),
      .rsp_valid  (rsp_valid[g]),
      .rsp_rdata  (rsp_rdata[g*DW +: DW]),
      .clk_en     (core_clk_en[g]),
      .arrive     (arrive[g]),
      .trig_valid (trig_valid[g]),
      .trig_evt   (trig_evt[g]),
      .trig_cores (trig_cores[g]),
      .bm_we      (bm_we[g]),
      .bm_wdata   (bm_wdata[g])
    );
  end

  evu_barrier #(.NC(NC)) i_barrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .arrive     (arrive),
    .bm_we      (bm_we),
    .bm_wdata   (bm_wdata),
    .bar_release(bar_release),
    .bar_mask   (bar_mask)
  );

  initial begin
    a_r5_trigger_fits: assert (TRIG_BITS <= DW);
  end

  // R4: a core whose enable comes back gets its load data in that cycle
  a_r4_wake_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(core_clk_en) & core_clk_en & ~rsp_valid) == '0));
endmodule

// File: tb/test_evu_top.sv
`timescale 1ns/1ps
module test_evu_top;
  localparam int NC = 8, NE = 8, AW = 3, DW = 32;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] req_valid, req_ready, req_write, rsp_valid, core_clk_en;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata, rsp_rdata;
  logic [NC*NE-1:0] evt_in;

  logic        b_valid [NC];
  logic        b_write [NC];
  logic [2:0]  b_addr  [NC];
  logic [31:0] b_wdata [NC];
  logic [7:0]  b_evt   [NC];

  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      req_valid[i]            = b_valid[i];
      req_write[i]            = b_write[i];
      req_addr[i*AW +: AW]    = b_addr[i];
      req_wdata[i*DW +: DW]   = b_wdata[i];
      evt_in[i*NE +: NE]      = b_evt[i];
    end
  end

  evu_top #(.NC(NC), .NE(NE), .AW(AW), .DW(DW)) i_evu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_in(evt_in),
    .core_clk_en(core_clk_en)
  );

  // behavioural reference model: 0 idle, 1 responding, 2 event wait, 3 barrier wait
  int          m_st   [NC];
  logic [7:0]  m_emask[NC];
  logic [7:0]  m_pend [NC];
  logic [31:0] m_rd   [NC];
  logic [7:0]  m_bm, m_arr;

  always @(posedge clk) begin : model
    logic [7:0] nev [NC];
    logic [7:0] nbm, arrv, h, clr;
    logic rel;
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_st[i] = 0; m_emask[i] = 0; m_pend[i] = 0; m_rd[i] = 0;
      end
      m_bm = 8'hFF; m_arr = 0;
    end else begin
      rel = (m_bm != 0) && ((m_arr & m_bm) == m_bm);
      nbm = m_bm; arrv = 0;
      for (int i = 0; i < NC; i++) nev[i] = b_evt[i];
      for (int j = NC - 1; j >= 0; j--)
        if (b_valid[j] && m_st[j] < 2 && b_write[j] && b_addr[j] == 2) nbm = b_wdata[j][7:0];
      for (int j = 0; j < NC; j++)
        if (b_valid[j] && m_st[j] < 2 && b_write[j] && b_addr[j] == 1)
          for (int i = 0; i < NC; i++) if (b_wdata[j][8+i]) nev[i] = nev[i] | b_wdata[j][7:0];
      for (int i = 0; i < NC; i++) begin
        clr = 0;
        h = m_pend[i] & m_emask[i];
        if (m_st[i] == 2) begin
          if (h != 0) begin m_st[i] = 1; m_rd[i] = {24'b0, h}; clr = h; end
        end else if (m_st[i] == 3) begin
          if (rel) begin m_st[i] = 1; m_rd[i] = {24'b0, m_bm}; end
        end else begin
          m_st[i] = 0;
          if (b_valid[i] && !b_write[i]) begin
            m_st[i] = 1;
            case (b_addr[i])
              0: m_rd[i] = {24'b0, m_emask[i]};
              1: m_rd[i] = {24'b0, m_pend[i]};
              2: m_rd[i] = {24'b0, m_bm};
              3: if (h != 0) begin m_rd[i] = {24'b0, h}; clr = h; end else m_st[i] = 2;
              4: begin m_st[i] = 3; arrv[i] = 1'b1; end
              default: m_rd[i] = 0;
            endcase
          end else if (b_valid[i] && b_write[i] && b_addr[i] == 0) begin
            m_emask[i] = b_wdata[i][7:0];
          end
        end
        m_pend[i] = (m_pend[i] & ~clr) | nev[i];
      end
      m_arr = (rel ? 8'h00 : m_arr) | arrv;
      m_bm = nbm;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NC; i++) begin
        checks++;
        if (core_clk_en[i] !== (m_st[i] < 2)) begin
          errors++;
          $display("FAIL R4 core %0d clk_en act %b exp %b", i, core_clk_en[i], m_st[i] < 2);
        end else if (req_ready[i] !== (m_st[i] < 2)) begin
          errors++;
          $display("FAIL R2 core %0d ready act %b exp %b", i, req_ready[i], m_st[i] < 2);
        end else if (rsp_valid[i] !== (m_st[i] == 1)) begin
          errors++;
          $display("FAIL R1 core %0d rsp_valid act %b exp %b", i, rsp_valid[i], m_st[i] == 1);
        end else if (m_st[i] == 1 && rsp_rdata[i*DW +: DW] !== m_rd[i]) begin
          errors++;
          $display("FAIL R1 core %0d rdata act %h exp %h", i, rsp_rdata[i*DW +: DW], m_rd[i]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic put(input int c, input logic w, input logic [2:0] a, input logic [31:0] d);
    b_valid[c] = 1'b1; b_write[c] = w; b_addr[c] = a; b_wdata[c] = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      b_valid[i] = 1'b0; b_write[i] = 1'b0; b_addr[i] = '0; b_wdata[i] = '0; b_evt[i] = '0;
    end
  endtask

  function automatic logic [31:0] rd(input int c);
    return rsp_rdata[c*DW +: DW];
  endfunction

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      b_valid[i] = 0; b_write[i] = 0; b_addr[i] = 0; b_wdata[i] = 0; b_evt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R11 clk_en", 32'(core_clk_en), 32'hFF);
    chk("R11 ready", 32'(req_ready), 32'hFF);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'h0);
    put(0, 0, 2, 0); step();
    chk("R11 barrier mask", rd(0), 32'hFF);
    // R1 mask write and read back
    put(1, 1, 0, 32'h0F); step();
    put(1, 0, 0, 0); step();
    chk("R1 event mask", rd(1), 32'h0F);
    // R3 immediate wait
    b_evt[1] = 8'h05; step();
    put(1, 0, 1, 0); step();
    chk("R1 pending", rd(1), 32'h05);
    put(1, 0, 3, 0); step();
    chk("R3 immediate valid", 32'(rsp_valid[1]), 32'h1);
    chk("R3 immediate data", rd(1), 32'h05);
    chk("R3 never gated", 32'(core_clk_en[1]), 32'h1);
    put(1, 0, 1, 0); step();
    chk("R3 cleared", rd(1), 32'h0);
    // R4 park, R5 software wake
    b_evt[1] = 8'h30; step();
    put(1, 0, 3, 0); step();
    chk("R4 parked", 32'(core_clk_en[1]), 32'h0);
    chk("R2 not ready", 32'(req_ready[1]), 32'h0);
    put(2, 1, 1, 32'h0201); step();
    chk("R4 still parked one edge after event", 32'(core_clk_en[1]), 32'h0);
    step();
    chk("R5 woken", 32'(core_clk_en[1]), 32'h1);
    chk("R5 wake data", rd(1), 32'h01);
    put(1, 0, 1, 0); step();
    chk("R3 unmasked kept", rd(1), 32'h30);
    // R6 event on the consuming edge
    put(1, 0, 3, 0); step();
    b_evt[1] = 8'h02; step();
    b_evt[1] = 8'h02; step();
    chk("R6 wake data", rd(1), 32'h02);
    put(1, 0, 1, 0); step();
    chk("R6 kept pending", rd(1), 32'h32);
    // R7 barrier
    put(0, 1, 2, 32'h07); step();
    put(0, 0, 4, 0); put(1, 0, 4, 0); step();
    chk("R7 early parked", 32'(core_clk_en[1:0]), 32'h0);
    put(2, 0, 4, 0); step();
    chk("R7 last arriver parked", 32'(core_clk_en[2:0]), 32'h0);
    step();
    chk("R7 all woken", 32'(core_clk_en[2:0]), 32'h7);
    chk("R7 all respond", 32'(rsp_valid[2:0]), 32'h7);
    chk("R7 data", rd(0), 32'h07);
    // R8 reuse
    put(0, 0, 4, 0); put(1, 0, 4, 0); put(2, 0, 4, 0); step();
    chk("R8 parked again", 32'(core_clk_en[2:0]), 32'h0);
    step();
    chk("R8 reused", 32'(rsp_valid[2:0]), 32'h7);
    // R9 non-participant
    put(5, 0, 4, 0); step();
    chk("R9 outsider parked", 32'(core_clk_en[5]), 32'h0);
    put(0, 0, 4, 0); put(1, 0, 4, 0); put(2, 0, 4, 0); step();
    step();
    chk("R9 outsider released", 32'(rsp_valid[5]), 32'h1);
    chk("R9 outsider data", rd(5), 32'h07);
    // R9 empty mask, R2 held write
    put(0, 1, 2, 0); step();
    put(3, 0, 4, 0); step();
    for (int k = 0; k < 4; k++) begin
      put(3, 1, 0, 32'h77);
      step();
      chk("R2 held not ready", 32'(req_ready[3]), 32'h0);
    end
    chk("R9 empty mask no release", 32'(core_clk_en[3]), 32'h0);
    put(0, 1, 2, 32'h08); step();
    chk("R9 mask pending", 32'(core_clk_en[3]), 32'h0);
    step();
    chk("R9 released by new mask", 32'(rsp_valid[3]), 32'h1);
    chk("R9 data", rd(3), 32'h08);
    put(3, 0, 0, 0); step();
    chk("R2 held write not taken", rd(3), 32'h0);
    // R10 ignored accesses and priority
    put(4, 1, 3, 32'hFF); step();
    put(4, 1, 5, 32'hAB); step();
    put(4, 0, 5, 0); step();
    chk("R10 unmapped reads zero", rd(4), 32'h0);
    put(4, 0, 0, 0); step();
    chk("R10 wait write ignored", rd(4), 32'h0);
    put(2, 1, 2, 32'h11); put(6, 1, 2, 32'h22); step();
    put(7, 0, 2, 0); step();
    chk("R10 lowest core wins", rd(7), 32'h11);
    // R5 self trigger merged with line
    put(4, 1, 0, 32'hFF); step();
    put(4, 1, 1, 32'h1010); b_evt[4] = 8'h01; step();
    put(4, 0, 3, 0); step();
    chk("R5 merged events", rd(4), 32'h11);
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule